// File: doc/BRIEF.md
# Register-List Transfer Address Sequencer

This block sets the order and the addresses of a multi-register memory transfer. It takes a bit mask that marks which of the registers take part, a base address and a direction. It then gives out one beat per marked register, lowest register number first. Each beat carries the register number and the word address for that access. Addresses form one contiguous run of words. Unmarked registers leave no hole in that run.

Two addressing directions are supported. In the upward walk (pop, or a plain increment-after load or store), the first beat uses the base and each later beat adds one word. In the downward walk (a full-descending push), the run ends just below the base. The lowest register still goes to the lowest address. When the run ends, the block pulses a done strobe. If write-back was requested at start, it also presents the updated base pointer, which is derived from the population count of the mask. Beats leave through a valid/ready handshake, so a slow memory port can stall the walk at any beat.

Top module: `regblk_addr_seq`

## Requirements
- R1: Beats are issued in strictly ascending register-number order over the set bits of the mask, one beat per set bit. Bit i of `mask_i` selects register i.
- R2: With `mode_i`=0 (upward), the first beat's address equals the base. Each following beat's address is the previous one plus 4.
- R3: With `mode_i`=0, the final base is the start base plus 4 times the number of set mask bits, taken modulo 2^AW.
- R4: With `mode_i`=1 (downward push), the first address is the base minus 4 times the count, and later beats add 4. The final base is the base minus 4 times the count.
- R5: While `beat_ready_i` is high, one beat is accepted per clock. While `beat_valid_o` is high and `beat_ready_i` is low, the valid, register and address outputs hold steady.
- R6: `done_o` is high for one cycle, in the cycle after the last beat is accepted. `wb_valid_o` is high with it exactly when `wb_en_i` was high at start. `wb_base_o` then shows the final base.
- R7: An all-zero mask issues no beat. `done_o` rises in the cycle after the start, with `wb_base_o` equal to the base.
- R8: A `start_i` pulse while a walk is in progress (`busy_o` high) is ignored. The running walk continues unchanged.
- R9: After reset, `beat_valid_o`, `busy_o`, `done_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a walk, accepted only when idle |
| mask_i | input | NREG | Register selection mask |
| base_i | input | AW | Base address |
| mode_i | input | 1 | 0 upward, 1 downward push |
| wb_en_i | input | 1 | Request base write-back |
| beat_valid_o | output | 1 | A beat is offered |
| beat_ready_i | input | 1 | Memory port takes the beat |
| beat_reg_o | output | IDXW | Register number of the beat |
| beat_addr_o | output | AW | Word address of the beat |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end strobe |
| wb_valid_o | output | 1 | Write-back value present |
| wb_base_o | output | AW | Updated base pointer |

## Verification
The checker watches four things on every cycle: beats stay stable under back-pressure, each accepted beat is followed by a higher register number at the next word address, done never overlaps an offered beat, and the write-back flag only appears with done. The bench scenarios are the only place that show absolute values. These are the first address in each direction, the final base computed from the population count (including address wrap), the empty-mask shortcut, and the rejection of a start issued in mid-walk.

// File: rtl/regblk_pkg.sv
package regblk_pkg;
  typedef enum logic {
    WALK_UP   = 1'b0,
    WALK_DOWN = 1'b1
  } walk_dir_e;
endpackage

// File: rtl/regblk_popcnt.sv
module regblk_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/regblk_lowbit.sv
module regblk_lowbit #(
  parameter int W    = 16,
  parameter int IDXW = $clog2(W)
) (
  input  logic [W-1:0]    vec_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o,
  output logic [W-1:0]    rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDXW'(i);
    end
    any_o  = |vec_i;
    rest_o = vec_i & ~(W'(1) << idx_o);
  end
endmodule

// File: rtl/regblk_addr_seq.sv
module regblk_addr_seq
  import regblk_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int IDXW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [AW-1:0]   base_i,
  input  logic            mode_i,
  input  logic            wb_en_i,
  output logic            beat_valid_o,
  input  logic            beat_ready_i,
  output logic [IDXW-1:0] beat_reg_o,
  output logic [AW-1:0]   beat_addr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            wb_valid_o,
  output logic [AW-1:0]   wb_base_o
);
  localparam int CW = $clog2(NREG + 1);
  localparam int SH = $clog2(WORD_BYTES);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [NREG-1:0] rem_q;
  logic            valid_q, done_q, wbv_q, wben_q;
  logic [IDXW-1:0] reg_q;
  logic [AW-1:0]   addr_q, wbb_q;

  logic            st_any, nx_any;
  logic [IDXW-1:0] st_idx, nx_idx;
  logic [NREG-1:0] st_rest, nx_rest;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   span, first_addr, final_base;
  walk_dir_e       dir;

  regblk_lowbit #(.W(NREG), .IDXW(IDXW)) u_pick_start (
    .vec_i(mask_i), .any_o(st_any), .idx_o(st_idx), .rest_o(st_rest)
  );

  regblk_lowbit #(.W(NREG), .IDXW(IDXW)) u_pick_next (
    .vec_i(rem_q), .any_o(nx_any), .idx_o(nx_idx), .rest_o(nx_rest)
  );

  regblk_popcnt #(.W(NREG), .CW(CW)) u_count (
    .vec_i(mask_i), .cnt_o(cnt)
  );

  always_comb begin
    dir        = walk_dir_e'(mode_i);
    span       = AW'(cnt) << SH;
    first_addr = (dir == WALK_DOWN) ? base_i - span : base_i;
    final_base = (dir == WALK_DOWN) ? base_i - span : base_i + span;
  end

  logic start_ok, fire;
  assign start_ok = start_i & ~valid_q;
  assign fire     = valid_q & beat_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      wbv_q   <= 1'b0;
      wben_q  <= 1'b0;
      reg_q   <= '0;
      addr_q  <= '0;
      wbb_q   <= '0;
    end else begin
      done_q <= 1'b0;
      wbv_q  <= 1'b0;
      if (start_ok) begin
        rem_q   <= st_rest;
        valid_q <= st_any;
        reg_q   <= st_idx;
        addr_q  <= first_addr;
        wbb_q   <= final_base;
        wben_q  <= wb_en_i;
        done_q  <= ~st_any;
        wbv_q   <= ~st_any & wb_en_i;
      end else if (fire) begin
        if (!nx_any) begin
          valid_q <= 1'b0;
          done_q  <= 1'b1;
          wbv_q   <= wben_q;
        end else begin
          reg_q  <= nx_idx;
          rem_q  <= nx_rest;
          addr_q <= addr_q + STEP;
        end
      end
    end
  end

  assign beat_valid_o = valid_q;
  assign beat_reg_o   = reg_q;
  assign beat_addr_o  = addr_q;
  assign busy_o       = valid_q;
  assign done_o       = done_q;
  assign wb_valid_o   = wbv_q;
  assign wb_base_o    = wbb_q;
endmodule

// File: rtl/regblk_addr_seq_chk.sv
module regblk_addr_seq_chk #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int IDXW       = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            beat_valid_o,
  input logic            beat_ready_i,
  input logic [IDXW-1:0] beat_reg_o,
  input logic [AW-1:0]   beat_addr_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            wb_valid_o
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && !beat_ready_i) |=>
      (beat_valid_o && $stable(beat_reg_o) && $stable(beat_addr_o)));

  a_r1_ascending: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && beat_ready_i) |=>
      (!beat_valid_o || beat_reg_o > $past(beat_reg_o)));

  a_r2_word_step: assert property (@(posedge clk) disable iff (rst)
    (beat_valid_o && beat_ready_i) |=>
      (!beat_valid_o || beat_addr_o == $past(beat_addr_o) + STEP));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !beat_valid_o);

  a_r6_wb_with_done: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> done_o);

  a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o && !beat_ready_i) |=> busy_o);
endmodule

bind regblk_addr_seq regblk_addr_seq_chk #(
  .AW(AW), .WORD_BYTES(WORD_BYTES), .IDXW(IDXW)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i),
  .beat_valid_o(beat_valid_o), .beat_ready_i(beat_ready_i),
  .beat_reg_o(beat_reg_o), .beat_addr_o(beat_addr_o),
  .busy_o(busy_o), .done_o(done_o), .wb_valid_o(wb_valid_o)
);

// File: tb/test_regblk_addr_seq.sv
module test_regblk_addr_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic [31:0] base_i = '0;
  logic        mode_i = 1'b0;
  logic        wb_en_i = 1'b0;
  logic        beat_ready_i = 1'b0;
  logic        beat_valid_o, busy_o, done_o, wb_valid_o;
  logic [3:0]  beat_reg_o;
  logic [31:0] beat_addr_o, wb_base_o;

  always #4 clk = ~clk;

  regblk_addr_seq i_regblk_addr_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .mask_i(mask_i), .base_i(base_i),
    .mode_i(mode_i), .wb_en_i(wb_en_i), .beat_valid_o(beat_valid_o),
    .beat_ready_i(beat_ready_i), .beat_reg_o(beat_reg_o), .beat_addr_o(beat_addr_o),
    .busy_o(busy_o), .done_o(done_o), .wb_valid_o(wb_valid_o), .wb_base_o(wb_base_o)
  );

  typedef struct packed {
    logic [15:0] m;
    logic [31:0] b;
    logic        md;
    logic        wb;
    logic [4:0]  n;
    logic [31:0] fin;
  } vec_t;

  localparam vec_t VT [5] = '{
    '{16'h00C3, 32'h0000_1000, 1'b0, 1'b1, 5'd4,  32'h0000_1010},
    '{16'h8001, 32'h0000_2000, 1'b1, 1'b1, 5'd2,  32'h0000_1FF8},
    '{16'hFFFF, 32'h0000_0100, 1'b0, 1'b0, 5'd16, 32'h0000_0140},
    '{16'h0410, 32'h0000_3000, 1'b1, 1'b1, 5'd2,  32'h0000_2FF8},
    '{16'h0001, 32'hFFFF_FFFC, 1'b0, 1'b1, 5'd1,  32'h0000_0000}
  };

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [15:0] m, input logic [31:0] b, input logic md, input logic wb);
    @(negedge clk);
    mask_i = m; base_i = b; mode_i = md; wb_en_i = wb; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Walks one sequence; expected beats derived from the mask directly.
  task automatic run_vec(input vec_t v, input bit stall);
    logic [31:0] exp_addr;
    int beat = 0;
    exp_addr = v.md ? v.fin : v.b;
    beat_ready_i = 1'b1;
    pulse_start(v.m, v.b, v.md, v.wb);
    for (int i = 0; i < 16; i++) begin
      if (v.m[i]) begin
        chk(beat_valid_o === 1'b1, "R5 beat offered", 32'(beat_valid_o), 32'd1);
        chk(beat_reg_o === 4'(i), "R1 register order", 32'(beat_reg_o), i);
        chk(beat_addr_o === exp_addr, v.md ? "R4 descending address" : "R2 ascending address",
            beat_addr_o, exp_addr);
        if (stall && beat == 1) begin
          beat_ready_i = 1'b0;
          @(negedge clk);
          chk(beat_valid_o === 1'b1 && beat_reg_o === 4'(i) && beat_addr_o === exp_addr,
              "R5 stall hold", beat_addr_o, exp_addr);
          beat_ready_i = 1'b1;
        end
        @(negedge clk);
        exp_addr = exp_addr + 32'd4;
        beat++;
      end
    end
    chk(beat == int'(v.n), "R1 beat count", beat, 32'(v.n));
    chk(done_o === 1'b1 && beat_valid_o === 1'b0, "R6 done after last beat", 32'(done_o), 32'd1);
    chk(wb_valid_o === v.wb, "R6 write-back flag", 32'(wb_valid_o), 32'(v.wb));
    chk(wb_base_o === v.fin, v.md ? "R4 final base" : "R3 final base", wb_base_o, v.fin);
    @(negedge clk);
    chk(done_o === 1'b0, "R6 done single cycle", 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(beat_valid_o === 1'b0 && busy_o === 1'b0, "R9 reset idle", 32'(beat_valid_o), 32'd0);
    chk(done_o === 1'b0 && wb_valid_o === 1'b0, "R9 reset strobes", 32'(done_o), 32'd0);

    for (int k = 0; k < 5; k++) run_vec(VT[k], (k % 2) == 0);

    // R7: empty mask, no beats, immediate done
    beat_ready_i = 1'b1;
    pulse_start(16'h0000, 32'h0000_4444, 1'b0, 1'b1);
    chk(done_o === 1'b1 && beat_valid_o === 1'b0, "R7 empty mask done", 32'(done_o), 32'd1);
    chk(wb_valid_o === 1'b1 && wb_base_o === 32'h0000_4444, "R7 empty mask base", wb_base_o, 32'h0000_4444);
    @(negedge clk);
    chk(beat_valid_o === 1'b0 && done_o === 1'b0, "R7 no beat after empty", 32'(beat_valid_o), 32'd0);

    // R8: start while busy ignored
    beat_ready_i = 1'b0;
    pulse_start(16'h0006, 32'h0000_0500, 1'b0, 1'b1);
    mask_i = 16'h0001; base_i = 32'h0000_0900; mode_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(beat_reg_o === 4'd1 && beat_addr_o === 32'h500, "R8 busy start ignored", beat_addr_o, 32'h500);
    beat_ready_i = 1'b1;
    @(negedge clk);
    chk(beat_reg_o === 4'd2 && beat_addr_o === 32'h504, "R8 walk continues", beat_addr_o, 32'h504);
    @(negedge clk);
    chk(done_o === 1'b1 && wb_base_o === 32'h508, "R8 original final base", wb_base_o, 32'h508);

    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule